// File: doc/BRIEF.md
# Software-Triggered Inter-Hart Interrupt Controller

This block lets harts interrupt one another by writing to memory-mapped registers. Each hart owns one interrupt source, and the source number is the hart index plus one. Source 0 does not exist and always reads as zero. Software raises an interrupt for hart `h` by writing a word with bit `h+1` set into the shared pending array.

The target hart services the interrupt with a claim/complete handshake. It reads its claim word to obtain the winning source, and that read also retires the pending bit. When handling is done, the hart writes the same ID back to the claim word. Each source has a priority, and each hart has an enable word and a threshold. Together these decide which pending sources may drive the hart's interrupt line, and which source wins a claim.

The register bus is a simple strobe interface with no back-pressure. A write completes in the cycle `bus_we` is high. A read launched with `bus_re` returns data on `bus_rdata` after the next clock edge, and `bus_rdata` holds that value until the next read. The bus never stalls, so there is no ready signal. `bus_we` and `bus_re` are not raised together; if they are, the write is performed and the read is dropped.

Top module: `swint_ctrl`

## Requirements
- R1: After reset, every priority, pending, enable, threshold and in-service bit is zero. Every `irq_o` line is low, and a claim read returns 0.
- R2: The pending array is at byte offset 0x1000. A write ORs data bits 1..NUM_HARTS into the pending set and never clears a bit. Bit 0 always reads 0, and writing it has no effect.
- R3: Hart h's enable word is at 0x2000 + h*0x80. Bit n enables source n for that hart. Bit 0 reads 0 and cannot be written.
- R4: Source n's priority word is at 4*n, and hart h's threshold word is at 0x200000 + h*0x1000. Both keep the low PRIO_W data bits, and the upper bits read back as zero.
- R5: `irq_o[h]` is high in the cycle after a register write exactly when some source is pending, enabled for hart h, not in service, and has a priority strictly above hart h's threshold. Priority 0 never interrupts.
- R6: A read of hart h's claim word (0x200004 + h*0x1000) returns the ID of the eligible source with the highest priority. Among equal priorities, the lowest ID wins. The read returns 0 when no source is eligible.
- R7: A claim read that returns a nonzero ID clears that source's pending bit and marks it in service. A source in service does not raise any interrupt line, even if it is made pending again.
- R8: Writing an ID to hart h's claim word ends service of that source only if hart h claimed it. A write with any other ID, with 0, or to another hart's claim word is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 22 | Byte address of the register access |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe; data appears on `bus_rdata` after the next edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | NUM_HARTS | Interrupt line for each hart |

## Verification
The main function is exercised with four kinds of patterns:
- A single source raised toward its own hart, which checks the basic claim and complete handshake.
- All sources raised at once, one per hart, which shows that the lines and claims stay separate per hart.
- Four sources pointed at one hart with mixed and tied priorities, which separates "highest priority wins" from "lowest ID wins" and shows the claim returning 0 once everything is drained.
- Threshold and priority edge values (equal to the threshold, one above it, and zero), which show the comparison is strict.

A final pattern re-raises a source while it is in service, then completes it first with a wrong ID, then from a foreign hart, then with 0, and only then correctly. This tells ignored completions apart from real ones.

// File: rtl/swint_pkg.sv
package swint_pkg;
  localparam int ADDR_W = 22;
  localparam int DATA_W = 32;

  // Register group hit by a bus address
  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_PRIO,
    SEL_PEND,
    SEL_EN,
    SEL_THR,
    SEL_CLAIM
  } sel_e;
endpackage

// File: rtl/swint_dec.sv
module swint_dec
  import swint_pkg::*;
#(
  parameter int NUM_HARTS = 4
) (
  input  logic [ADDR_W-1:0] addr,
  output sel_e              kind,
  output logic [4:0]        idx
);
  localparam logic [4:0] LAST = 5'(NUM_HARTS);

  always_comb begin
    kind = SEL_NONE;
    idx  = '0;
    if (addr[21:12] == 10'h000) begin
      // priority words: 4*n, n in 1..NUM_HARTS
      if (addr[11:7] == 5'd0 && addr[1:0] == 2'd0 &&
          addr[6:2] != 5'd0 && addr[6:2] <= LAST) begin
        kind = SEL_PRIO;
        idx  = addr[6:2];
      end
    end else if (addr == 22'h001000) begin
      kind = SEL_PEND;
    end else if (addr[21:12] == 10'h002) begin
      if (addr[6:0] == 7'd0 && addr[11:7] < LAST) begin
        kind = SEL_EN;
        idx  = addr[11:7];
      end
    end else if (addr[21] && addr[20:17] == 4'd0 && addr[16:12] < LAST) begin
      idx = addr[16:12];
      if (addr[11:0] == 12'h000)      kind = SEL_THR;
      else if (addr[11:0] == 12'h004) kind = SEL_CLAIM;
    end
  end
endmodule

// File: rtl/swint_arb.sv
module swint_arb #(
  parameter int NSRC   = 4,
  parameter int PRIO_W = 3,
  parameter int ID_W   = 3
) (
  input  logic [NSRC:1]             pend,
  input  logic [NSRC:1]             en,
  input  logic [NSRC:1]             busy,
  input  logic [NSRC:1][PRIO_W-1:0] prio,
  input  logic [PRIO_W-1:0]         thr,
  output logic [ID_W-1:0]           id,
  output logic                      vld
);
  logic [PRIO_W-1:0] best;

  // Ascending scan with a strict compare keeps the lowest ID on ties.
  always_comb begin
    id   = '0;
    vld  = 1'b0;
    best = '0;
    for (int s = 1; s <= NSRC; s++) begin
      if (pend[s] && en[s] && !busy[s] && prio[s] > thr) begin
        if (!vld || prio[s] > best) begin
          vld  = 1'b1;
          best = prio[s];
          id   = ID_W'(s);
        end
      end
    end
  end
endmodule

// File: rtl/swint_ctrl.sv
module swint_ctrl
  import swint_pkg::*;
#(
  parameter int NUM_HARTS = 4,
  parameter int PRIO_W    = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [21:0]          bus_addr,
  input  logic                 bus_we,
  input  logic                 bus_re,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  output logic [NUM_HARTS-1:0] irq_o
);
  localparam int NSRC = NUM_HARTS;
  localparam int ID_W = $clog2(NSRC + 1);

  logic [NSRC:1][PRIO_W-1:0]          prio_q;
  logic [NSRC:1]                      pend_q;
  logic [NUM_HARTS-1:0][NSRC:1]       en_q;
  logic [NUM_HARTS-1:0][NSRC:1]       insvc_q;
  logic [NUM_HARTS-1:0][PRIO_W-1:0]   thr_q;
  logic [NUM_HARTS-1:0][ID_W-1:0]     arb_id;
  logic [NUM_HARTS-1:0]               arb_vld;
  logic [NSRC:1]                      busy;

  sel_e       kind;
  logic [4:0] idx;
  logic [ID_W-1:0] cmpl_id;
  logic       cmpl_ok;
  logic       claim_rd;

  swint_dec #(.NUM_HARTS(NUM_HARTS)) dec_i (
    .addr (bus_addr),
    .kind (kind),
    .idx  (idx)
  );

  // A source is busy while any hart holds it in service
  always_comb begin
    busy = '0;
    for (int h = 0; h < NUM_HARTS; h++) busy = busy | insvc_q[h];
  end

  for (genvar h = 0; h < NUM_HARTS; h++) begin : g_hart
    swint_arb #(.NSRC(NSRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) arb_i (
      .pend (pend_q),
      .en   (en_q[h]),
      .busy (busy),
      .prio (prio_q),
      .thr  (thr_q[h]),
      .id   (arb_id[h]),
      .vld  (arb_vld[h])
    );
    assign irq_o[h] = arb_vld[h];
  end

  assign cmpl_id  = bus_wdata[ID_W-1:0];
  assign cmpl_ok  = (bus_wdata != 32'd0) && (bus_wdata <= 32'(NSRC)) &&
                    insvc_q[idx][cmpl_id];
  assign claim_rd = bus_re && !bus_we && (kind == SEL_CLAIM) && arb_vld[idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prio_q  <= '0;
      pend_q  <= '0;
      en_q    <= '0;
      insvc_q <= '0;
      thr_q   <= '0;
    end else if (bus_we) begin
      case (kind)
        SEL_PRIO:  prio_q[idx] <= bus_wdata[PRIO_W-1:0];
        SEL_PEND:  pend_q      <= pend_q | bus_wdata[NSRC:1];
        SEL_EN:    en_q[idx]   <= bus_wdata[NSRC:1];
        SEL_THR:   thr_q[idx]  <= bus_wdata[PRIO_W-1:0];
        SEL_CLAIM: if (cmpl_ok) insvc_q[idx][cmpl_id] <= 1'b0;
        default: ;
      endcase
    end else if (claim_rd) begin
      pend_q[arb_id[idx]]       <= 1'b0;
      insvc_q[idx][arb_id[idx]] <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= '0;
    end else if (bus_re && !bus_we) begin
      case (kind)
        SEL_PRIO:  bus_rdata <= 32'(prio_q[idx]);
        SEL_PEND:  bus_rdata <= 32'({pend_q, 1'b0});
        SEL_EN:    bus_rdata <= 32'({en_q[idx], 1'b0});
        SEL_THR:   bus_rdata <= 32'(thr_q[idx]);
        SEL_CLAIM: bus_rdata <= 32'(arb_id[idx]);
        default:   bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/swint_ctrl_chk.sv
module swint_ctrl_chk #(
  parameter int NUM_HARTS = 4
) (
  input logic                               clk,
  input logic                               rst_n,
  input logic [21:0]                        bus_addr,
  input logic                               bus_we,
  input logic                               bus_re,
  input logic [31:0]                        bus_rdata,
  input logic [NUM_HARTS-1:0]               irq_o,
  input logic [NUM_HARTS:1]                 pend_q,
  input logic [NUM_HARTS-1:0][NUM_HARTS:1]  insvc_q
);
  localparam int ID_W = $clog2(NUM_HARTS + 1);

  logic claim_acc;
  logic pend_acc;
  assign claim_acc = bus_re && !bus_we && bus_addr[21] && bus_addr[20:17] == 4'd0 &&
                     bus_addr[16:12] < 5'(NUM_HARTS) && bus_addr[11:0] == 12'h004;
  assign pend_acc  = bus_re && !bus_we && bus_addr == 22'h001000;

  // R1
  rst_quiet_chk: assert property (@(posedge clk) $rose(rst_n) |-> irq_o == '0);

  // R2
  pend_bit0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pend_acc) |-> bus_rdata[0] == 1'b0);

  // R5
  irq_needs_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_o) |-> (|pend_q));

  // R6
  claim_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(claim_acc) |-> bus_rdata <= 32'(NUM_HARTS));

  // R7
  claim_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(claim_acc) && bus_rdata != 32'd0 && bus_rdata <= 32'(NUM_HARTS))
      |-> !pend_q[bus_rdata[ID_W-1:0]]);

  for (genvar s = 1; s <= NUM_HARTS; s++) begin : g_src
    logic [NUM_HARTS-1:0] col;
    always_comb begin
      for (int h = 0; h < NUM_HARTS; h++) col[h] = insvc_q[h][s];
    end
    // R8
    one_owner_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(col));
  end
endmodule

bind swint_ctrl swint_ctrl_chk #(.NUM_HARTS(NUM_HARTS)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_we    (bus_we),
  .bus_re    (bus_re),
  .bus_rdata (bus_rdata),
  .irq_o     (irq_o),
  .pend_q    (pend_q),
  .insvc_q   (insvc_q)
);

// File: tb/swint_ctrl_tb_top.sv
module swint_ctrl_tb_top;
  localparam int NH = 4;
  localparam logic [21:0] PEND = 22'h001000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [21:0]   bus_addr = '0;
  logic          bus_we = 1'b0;
  logic          bus_re = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NH-1:0] irq_o;

  int vectors = 0;
  int miscompares = 0;

  always #2 clk = ~clk;

  swint_ctrl #(.NUM_HARTS(NH), .PRIO_W(3)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_re(bus_re), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  function automatic logic [21:0] a_prio(int n);  return 22'(4 * n); endfunction
  function automatic logic [21:0] a_en(int h);    return 22'(32'h2000 + h * 32'h80); endfunction
  function automatic logic [21:0] a_thr(int h);   return 22'(32'h200000 + h * 32'h1000); endfunction
  function automatic logic [21:0] a_claim(int h); return 22'(32'h200004 + h * 32'h1000); endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [21:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [21:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
    d = bus_rdata;
  endtask

  task automatic defaults();
    for (int h = 0; h < NH; h++) wr(a_en(h), 32'(1) << (h + 1));
    for (int n = 1; n <= NH; n++) wr(a_prio(n), 32'd1);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 irq", 32'(irq_o), 32'd0);
    rd(PEND, d);        check("R1 pend", d, 32'd0);
    rd(a_en(0), d);     check("R1 en0", d, 32'd0);
    rd(a_thr(1), d);    check("R1 thr1", d, 32'd0);
    rd(a_prio(2), d);   check("R1 prio2", d, 32'd0);
    rd(a_claim(0), d);  check("R1 claim0", d, 32'd0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr(PEND, 32'h1);    rd(PEND, d);    check("R2 bit0 ignored", d, 32'd0);
    wr(PEND, 32'h4);    rd(PEND, d);    check("R2 set src2", d, 32'h4);
    wr(PEND, 32'h8);    rd(PEND, d);    check("R2 OR not overwrite", d, 32'hC);
    check("R5 not enabled", 32'(irq_o), 32'd0);
    wr(a_en(0), 32'h3); rd(a_en(0), d); check("R3 en bit0", d, 32'h2);
    wr(a_prio(1), 32'hFF); rd(a_prio(1), d); check("R4 prio width", d, 32'h7);
    wr(a_thr(2), 32'h5);   rd(a_thr(2), d);  check("R4 thr", d, 32'h5);
    wr(a_thr(2), 32'h0);
    // drain sources 2 and 3 through hart 0
    wr(a_prio(2), 32'd1); wr(a_prio(3), 32'd1); wr(a_en(0), 32'hC);
    rd(a_claim(0), d); check("R6 drain a", d, 32'd2);
    rd(a_claim(0), d); check("R6 drain b", d, 32'd3);
    wr(a_claim(0), 32'd2); wr(a_claim(0), 32'd3);
    rd(PEND, d); check("R7 drained", d, 32'd0);
  endtask

  task automatic t_basic();
    logic [31:0] d;
    defaults();
    wr(PEND, 32'h2);       check("R5 irq0 raised", 32'(irq_o), 32'h1);
    rd(a_claim(0), d);     check("R6 claim id", d, 32'd1);
    check("R7 irq drops", 32'(irq_o), 32'd0);
    rd(PEND, d);           check("R7 pend cleared", d, 32'd0);
    wr(a_claim(0), 32'd1); check("R8 complete quiet", 32'(irq_o), 32'd0);
    rd(a_claim(0), d);     check("R6 empty claim", d, 32'd0);
  endtask

  task automatic t_multi();
    logic [31:0] d;
    wr(PEND, 32'h1E);  check("R5 all lines", 32'(irq_o), 32'hF);
    for (int h = 0; h < NH; h++) begin
      rd(a_claim(h), d); check("R6 per-hart claim", d, 32'(h + 1));
    end
    check("R7 all drop", 32'(irq_o), 32'd0);
    for (int h = 0; h < NH; h++) wr(a_claim(h), 32'(h + 1));
  endtask

  task automatic t_thresh();
    logic [31:0] d;
    wr(a_prio(1), 32'd3); wr(a_thr(0), 32'd3);
    wr(PEND, 32'h2);       check("R5 equal to thr", 32'(irq_o), 32'd0);
    rd(a_claim(0), d);     check("R6 none eligible", d, 32'd0);
    wr(a_thr(0), 32'd2);   check("R5 above thr", 32'(irq_o), 32'h1);
    wr(a_thr(0), 32'd0); wr(a_prio(1), 32'd0);
    check("R5 prio zero", 32'(irq_o), 32'd0);
    wr(a_prio(1), 32'd1);  check("R5 prio one", 32'(irq_o), 32'h1);
    rd(a_claim(0), d);     check("R6 thr claim", d, 32'd1);
    wr(a_claim(0), 32'd1);
  endtask

  task automatic t_arb();
    logic [31:0] d;
    for (int h = 1; h < NH; h++) wr(a_en(h), 32'd0);
    wr(a_en(0), 32'h1E);
    wr(a_prio(1), 32'd2); wr(a_prio(2), 32'd5); wr(a_prio(3), 32'd5); wr(a_prio(4), 32'd1);
    wr(PEND, 32'h1E);
    rd(a_claim(0), d); check("R6 tie low id", d, 32'd2);
    rd(a_claim(0), d); check("R6 tie next", d, 32'd3);
    rd(a_claim(0), d); check("R6 mid prio", d, 32'd1);
    rd(a_claim(0), d); check("R6 low prio", d, 32'd4);
    rd(a_claim(0), d); check("R6 drained", d, 32'd0);
    for (int n = 1; n <= NH; n++) wr(a_claim(0), 32'(n));
    defaults();
  endtask

  task automatic t_insvc();
    logic [31:0] d;
    wr(PEND, 32'h2);
    rd(a_claim(0), d);     check("R7 claim", d, 32'd1);
    wr(PEND, 32'h2);       check("R7 held in service", 32'(irq_o), 32'd0);
    rd(PEND, d);           check("R7 re-pended", d, 32'h2);
    wr(a_claim(0), 32'd3); check("R8 wrong id", 32'(irq_o), 32'd0);
    wr(a_claim(1), 32'd1); check("R8 foreign hart", 32'(irq_o), 32'd0);
    wr(a_claim(0), 32'd0); check("R8 zero id", 32'(irq_o), 32'd0);
    wr(a_claim(0), 32'd1); check("R8 real complete", 32'(irq_o), 32'h1);
    rd(a_claim(0), d);     check("R8 reclaim", d, 32'd1);
    wr(a_claim(0), 32'd1); check("R8 idle", 32'(irq_o), 32'd0);
  endtask

  initial begin
    #(200000 * 4);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_basic();
    t_multi();
    t_thresh();
    t_arb();
    t_insvc();
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule